// File: doc/BRIEF.md
# Pixel Run Fill and Copy Engine

This block is a memory-mapped engine that draws short horizontal runs into a linear buffer of 8-bit pixels. Software first writes a colour word, then writes a command. The bus address of the command write selects the first destination pixel. The command word holds a source pixel address and a run length.

A source value of all ones requests a solid fill with the low byte of the stored colour. Any other source value requests a copy from source to destination. The copy runs from the lowest pixel to the highest, one pixel at a time.

The pixel store is an internal synchronous RAM with one read port and one write port. The RAM depth is `2**PIX_AW` pixels, 4096 by default. Every pixel write the engine makes is also driven onto output ports, so a system model can track the frame buffer contents. While a run is in progress the engine raises `busy` and holds `bus_ready` low. When the last pixel of a run is written, it gives a one-cycle `done` pulse.

Top module: `blit_engine`

## Requirements
- R1: An accepted write whose byte address has bit 2 at 0 only stores the colour word. No pixel write follows, and `busy` stays low on the next cycle.
- R2: An accepted write whose byte address has bit 2 at 1 is a command. Its first destination pixel is byte address bits 22..3, taken as a 20-bit index and reduced modulo the RAM depth. Address bits 1..0 and bits above 22 have no effect.
- R3: If command bits 23..0 equal 24'hFFFFFF, each pixel of the run, from the destination upward, is written with bits 7..0 of the stored colour, one pixel per cycle.
- R4: With any other value in bits 23..0, pixel i of the run is read from (source + i) and then written to (destination + i). i counts up from 0, and each read sees all earlier writes of the same run, so overlapping runs repeat the pattern. A copy takes two cycles per pixel. A source whose low bits happen to be all ones is still a copy.
- R5: Command bits 28..24 hold the run length minus one, so a run is 1 to 32 pixels. Command bits 31..29 have no effect.
- R6: Reads of the engine return zero at all times, including while a run is in progress.
- R7: `busy` is high from the cycle after the command is accepted through the cycle of the last pixel write. While `busy` is high, `bus_ready` is low, and a write presented then is dropped: it neither changes the colour nor starts a run.
- R8: `done` is high for exactly one cycle, in the cycle after the final pixel write of each run.
- R9: Pixel addresses of source and destination wrap modulo the RAM depth during a run.
- R10: During and after reset, `busy`, `done` and `pix_we` are low. `bus_ready` is high once reset has been released for two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, accepted when `bus_ready` is high |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | BUS_AW | Byte address within the engine window |
| bus_wdata | input | 32 | Write data: colour word or command word |
| bus_rdata | output | 32 | Read data, always zero |
| bus_ready | output | 1 | Engine can accept a write |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last pixel write |
| pix_we | output | 1 | Pixel write strobe to the RAM |
| pix_waddr | output | PIX_AW | Pixel write address |
| pix_wdata | output | 8 | Pixel write data |

## Verification
The bound checker checks these on every cycle:
- pixel writes occur only while `busy` is high;
- `done` is a single-cycle pulse that follows a pixel write;
- a command write raises `busy` on the next cycle, and a colour write does not;
- write addresses step by one, modulo the depth, both within a fill and between the read/write pairs of a copy.

Only the bench's scenarios can show the following:
- the pixel values themselves, from both the colour and the source;
- the replicated pattern of an overlapping forward copy;
- the decoding of the destination from the bus address;
- that a write dropped while busy leaves the colour unchanged.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam int unsigned CMD_SRC_W = 24;
  localparam int unsigned CMD_LEN_W = 5;
  localparam int unsigned DST_IDX_W = 20;
  localparam logic [CMD_SRC_W-1:0] FILL_CODE = '1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } blit_state_e;

  typedef struct packed {
    logic [CMD_SRC_W-1:0] src;
    logic [CMD_LEN_W-1:0] len_m1;
    logic                 fill;
  } blit_cmd_t;

  function automatic blit_cmd_t decode_cmd(input logic [31:0] word);
    blit_cmd_t c;
    c.src    = word[CMD_SRC_W-1:0];
    c.len_m1 = word[CMD_SRC_W +: CMD_LEN_W];
    c.fill   = (word[CMD_SRC_W-1:0] == FILL_CODE);
    return c;
  endfunction

endpackage

// File: rtl/blit_pixel_ram.sv
module blit_pixel_ram #(
  parameter int unsigned PIX_AW = 12,
  parameter int unsigned PIX_W  = 8
) (
  input  logic              clk,
  input  logic              re,
  input  logic [PIX_AW-1:0] raddr,
  output logic [PIX_W-1:0]  rdata,
  input  logic              we,
  input  logic [PIX_AW-1:0] waddr,
  input  logic [PIX_W-1:0]  wdata
);
  localparam int unsigned DEPTH = 1 << PIX_AW;

  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/blit_bus_front.sv
module blit_bus_front
  import blit_pkg::*;
#(
  parameter int unsigned BUS_AW = 24,
  parameter int unsigned PIX_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              seq_busy,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic              start,
  output blit_cmd_t         cmd,
  output logic [PIX_AW-1:0] dst,
  output logic [7:0]        colour
);
  localparam int unsigned IDX_LSB = 3;
  localparam int unsigned IDX_MSB = IDX_LSB + DST_IDX_W - 1;

  logic                 accept;
  logic                 colour_en;
  logic [7:0]           colour_q;
  logic [DST_IDX_W-1:0] dst_full;
  logic                 unused_front;

  assign bus_ready = enable & ~seq_busy;
  assign accept    = bus_wr & bus_ready;
  assign colour_en = accept & ~bus_addr[2];
  assign start     = accept &  bus_addr[2];
  assign cmd       = decode_cmd(bus_wdata);
  assign dst_full  = bus_addr[IDX_MSB:IDX_LSB];
  assign dst       = dst_full[PIX_AW-1:0];
  assign colour    = colour_q;

  assign unused_front = ^{bus_addr[1:0], bus_addr[BUS_AW-1:IDX_MSB+1],
                          dst_full, bus_wdata[31:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) colour_q <= '0;
    else if (colour_en) colour_q <= bus_wdata[7:0];
  end
endmodule

// File: rtl/blit_sequencer.sv
module blit_sequencer
  import blit_pkg::*;
#(
  parameter int unsigned PIX_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  blit_cmd_t         cmd,
  input  logic [PIX_AW-1:0] dst,
  input  logic [7:0]        colour,
  input  logic [7:0]        ram_rdata,
  output logic              busy,
  output logic              done,
  output logic              ram_re,
  output logic [PIX_AW-1:0] ram_raddr,
  output logic              ram_we,
  output logic [PIX_AW-1:0] ram_waddr,
  output logic [7:0]        ram_wdata
);
  localparam int unsigned PAD_W = PIX_AW - CMD_LEN_W;

  blit_state_e          state_q, state_d;
  logic [CMD_LEN_W-1:0] idx_q, idx_d, len_q;
  logic [PIX_AW-1:0]    src_q, dst_q, offset;
  logic                 idx_en, load_en, done_d, last;
  logic                 unused_seq;

  assign offset     = {{PAD_W{1'b0}}, idx_q};
  assign last       = (idx_q == len_q);
  assign load_en    = (state_q == ST_IDLE) & start;
  assign unused_seq = ^cmd.src[CMD_SRC_W-1:PIX_AW];

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q + 1'b1;
    idx_en    = 1'b0;
    done_d    = 1'b0;
    ram_re    = 1'b0;
    ram_we    = 1'b0;
    ram_raddr = src_q + offset;
    ram_waddr = dst_q + offset;
    ram_wdata = ram_rdata;
    unique case (state_q)
      ST_IDLE: begin
        idx_d  = '0;
        idx_en = start;
        if (start) state_d = cmd.fill ? ST_FILL : ST_READ;
      end
      ST_FILL: begin
        ram_we    = 1'b1;
        ram_wdata = colour;
        idx_en    = ~last;
        done_d    = last;
        if (last) state_d = ST_IDLE;
      end
      ST_READ: begin
        ram_re  = 1'b1;
        state_d = ST_WRITE;
      end
      ST_WRITE: begin
        ram_we  = 1'b1;
        idx_en  = ~last;
        done_d  = last;
        state_d = last ? ST_IDLE : ST_READ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      if (idx_en) idx_q <= idx_d;
      if (load_en) begin
        len_q <= cmd.len_m1;
        src_q <= cmd.src[PIX_AW-1:0];
        dst_q <= dst;
      end
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int unsigned BUS_AW = 24,
  parameter int unsigned PIX_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              busy,
  output logic              done,
  output logic              pix_we,
  output logic [PIX_AW-1:0] pix_waddr,
  output logic [7:0]        pix_wdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              start;
  blit_cmd_t         cmd;
  logic [PIX_AW-1:0] dst;
  logic [7:0]        colour;
  logic              ram_re;
  logic [PIX_AW-1:0] ram_raddr;
  logic [7:0]        ram_rdata;
  logic              unused_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign bus_rdata  = '0;
  assign unused_top = bus_rd;

  blit_bus_front #(.BUS_AW(BUS_AW), .PIX_AW(PIX_AW)) i_front (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .enable    (rst_int_n),
    .seq_busy  (busy),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .start     (start),
    .cmd       (cmd),
    .dst       (dst),
    .colour    (colour)
  );

  blit_sequencer #(.PIX_AW(PIX_AW)) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .cmd       (cmd),
    .dst       (dst),
    .colour    (colour),
    .ram_rdata (ram_rdata),
    .busy      (busy),
    .done      (done),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .ram_we    (pix_we),
    .ram_waddr (pix_waddr),
    .ram_wdata (pix_wdata)
  );

  blit_pixel_ram #(.PIX_AW(PIX_AW), .PIX_W(8)) i_ram (
    .clk   (clk),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata),
    .we    (pix_we),
    .waddr (pix_waddr),
    .wdata (pix_wdata)
  );
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk #(
  parameter int unsigned BUS_AW = 24,
  parameter int unsigned PIX_AW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_ready,
  input logic              busy,
  input logic              done,
  input logic              pix_we,
  input logic [PIX_AW-1:0] pix_waddr
);
  // R7: pixel writes only happen inside a run
  p_we_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_we |-> busy);

  // R8: done follows the final write, and the engine is idle by then
  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(pix_we) && !busy));

  // R8: done lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: an accepted command starts a run on the next cycle
  p_cmd_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ready && bus_addr[2]) |=> busy);

  // R1: a colour write starts nothing
  p_colour_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ready && !bus_addr[2]) |=> (!busy && !pix_we));

  // R3 / R9: back-to-back fill writes step by one, wrapping at the depth
  p_fill_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_we && $past(pix_we)) |-> (pix_waddr == PIX_AW'($past(pix_waddr) + 1'b1)));

  // R4 / R9: copy writes, two cycles apart within one run, step by one
  p_copy_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_we && !$past(pix_we) && $past(pix_we, 2) && !$past(done))
      |-> (pix_waddr == PIX_AW'($past(pix_waddr, 2) + 1'b1)));
endmodule

bind blit_engine blit_engine_chk #(.BUS_AW(BUS_AW), .PIX_AW(PIX_AW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_ready (bus_ready),
  .busy      (busy),
  .done      (done),
  .pix_we    (pix_we),
  .pix_waddr (pix_waddr)
);

// File: tb/test_blit_engine.sv
`timescale 1ns/1ps
module test_blit_engine;
  localparam int unsigned BUS_AW = 24;
  localparam int unsigned PIX_AW = 12;
  localparam int unsigned DEPTH  = 1 << PIX_AW;

  logic              clk;
  logic              rst_n;
  logic              bus_wr;
  logic              bus_rd;
  logic [BUS_AW-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic              bus_ready;
  logic              busy;
  logic              done;
  logic              pix_we;
  logic [PIX_AW-1:0] pix_waddr;
  logic [7:0]        pix_wdata;

  blit_engine #(.BUS_AW(BUS_AW), .PIX_AW(PIX_AW)) i_blit_engine (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .busy(busy), .done(done), .pix_we(pix_we),
    .pix_waddr(pix_waddr), .pix_wdata(pix_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    int unsigned addr;
    int unsigned data;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int unsigned model_mem [DEPTH];
  int unsigned model_colour;
  int          n_checks = 0;
  int          n_errors = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Monitor: every pixel write is compared with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && pix_we) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7", "unexpected pixel write addr", longint'(pix_waddr), 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(pix_waddr == e.addr[PIX_AW-1:0], e.tag, "pixel addr",
              longint'(pix_waddr), longint'(e.addr));
        check(pix_wdata == e.data[7:0], e.tag, "pixel data",
              longint'(pix_wdata), longint'(e.data));
      end
    end
  end

  task automatic bus_write(input logic [BUS_AW-1:0] a, input logic [31:0] d);
    while (!bus_ready) @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic wait_run(input int exp_cycles, input string tag);
    int n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(n == exp_cycles, tag, "R7 busy cycles", n, exp_cycles);
    check(done == 1'b1, "R8", "done after last write", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R8", "done single cycle", done, 0);
    check(sb_q.size() == 0, tag, "pending writes", sb_q.size(), 0);
  endtask

  task automatic set_colour(input logic [31:0] c);
    bus_write(24'h000010, c);
    model_colour = c[7:0];
    check(busy == 1'b0, "R1", "busy after colour write", busy, 0);
    check(pix_we == 1'b0, "R1", "pixel write after colour write", pix_we, 0);
  endtask

  task automatic push_fill(input logic [BUS_AW-1:0] off, input int len);
    int unsigned d0;
    d0 = ((off >> 3) & 32'hFFFFF) % DEPTH;
    for (int i = 0; i < len; i++) begin
      exp_t e;
      e.addr = (d0 + i) % DEPTH;
      e.data = model_colour;
      e.tag  = "R3";
      model_mem[e.addr] = model_colour;
      sb_q.push_back(e);
    end
  endtask

  task automatic do_fill(input logic [BUS_AW-1:0] off, input int len,
                         input logic [2:0] hi);
    push_fill(off, len);
    bus_write(off, {hi, 5'(len - 1), 24'hFFFFFF});
    wait_run(len, "R3");
  endtask

  task automatic do_copy(input logic [23:0] src, input int unsigned dst,
                         input int len, input string tag);
    for (int i = 0; i < len; i++) begin
      exp_t e;
      e.addr = (dst + i) % DEPTH;
      e.data = model_mem[(src + i) % DEPTH];
      e.tag  = tag;
      model_mem[e.addr] = e.data;
      sb_q.push_back(e);
    end
    bus_write(24'((dst << 3) | 4), {3'b000, 5'(len - 1), src});
    wait_run(2 * len, tag);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; model_colour = 0;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && pix_we == 0, "R10", "outputs in reset",
          {busy, done, pix_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(bus_ready == 1'b1, "R10", "ready after reset", bus_ready, 1);
    check(busy == 0 && done == 0, "R10", "idle after reset", {busy, done}, 0);

    bus_rd = 1'b1; bus_addr = 24'h00000C;
    @(negedge clk);
    check(bus_rdata == 0, "R6", "read data idle", bus_rdata, 0);
    bus_rd = 1'b0;

    // Fill of 32 with the upper command bits set (R3, R5)
    set_colour(32'h123456A5);
    do_fill(24'((100 << 3) | 4), 32, 3'b111);

    // Destination decoding: low bits and bit above the 20-bit index ignored (R2, R5)
    set_colour(32'hFFFFFF3C);
    do_fill(24'h800000 | 24'((200 << 3) | 7), 1, 3'b000);

    // Plain copy and an overlapping forward copy (R4)
    do_copy(24'd100, 300, 8, "R4");
    do_copy(24'd100, 103, 12, "R4");

    // Wrapping fill and copies across the top of the RAM (R9)
    set_colour(32'h00000077);
    do_fill(24'((4094 << 3) | 4), 4, 3'b010);
    do_copy(24'h000FFF, 20, 3, "R9");
    do_copy(24'd100, 4093, 5, "R9");

    // Writes presented while busy are dropped (R7), reads stay zero (R6)
    set_colour(32'h0000005A);
    push_fill(24'((500 << 3) | 4), 16);
    bus_write(24'((500 << 3) | 4), {8'h0F, 24'hFFFFFF});
    check(bus_ready == 1'b0, "R7", "ready while busy", bus_ready, 0);
    bus_wr = 1'b1; bus_addr = 24'h000000; bus_wdata = 32'h000000EE;
    @(negedge clk);
    bus_addr = 24'((50 << 3) | 4); bus_wdata = {8'h02, 24'hFFFFFF};
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 24'h000004;
    @(negedge clk);
    check(bus_rdata == 0, "R6", "read data busy", bus_rdata, 0);
    bus_rd = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R7", "no run from dropped command", busy, 0);
    check(sb_q.size() == 0, "R7", "writes left after dropped command", sb_q.size(), 0);
    do_fill(24'((700 << 3) | 4), 2, 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL R7 watchdog expired: actual busy %0d expected 0", busy);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule